// File: doc/BRIEF.md
# Sparsified Multichannel Readout Sequencer

This block orders the readout of a bank of processing channels toward an off-chip pipelined ADC. When a readout is requested and the chip is addressed, it takes a snapshot of which channels are to be read. It then presents them one per clock, lowest index first. For each presented channel it drives a one-hot select strobe and a binary channel address, both registered on the same edge as a data-valid strobe. The select strobe steers external analog multiplexers, so the address stays aligned with the sample the ADC takes.

A mode input picks between two readouts. In sparse mode only channels with a hit are read, and a channel whose discriminator output is disabled counts as having no hit. In full mode every channel is read. Because the next eligible channel is found by a priority pick over the remaining flags, a sparse readout has no idle cycles between hits. One cycle after the last channel is presented, a single-cycle done flag is raised and the block returns to idle.

Top module: `readout_sequencer`

## Requirements
- R1: After reset, `addr_o` is 0, `sel_o` is all zeros, and `valid_o` and `done_o` are low.
- R2: A readout starts only when `start_i` and `chip_sel_i` are both high in idle; `start_i` with `chip_sel_i` low leaves all outputs quiet.
- R3: With `all_mode_i` = 0 at start, the channels with `hit_i[c]` = 1 and `chan_en_i[c]` = 1 are presented in ascending order on consecutive clocks, the first one in the cycle after the start is sampled.
- R4: With `all_mode_i` = 1 at start, all 32 channels are presented as 0, 1, …, 31 on 32 consecutive clocks, whatever the hit flags.
- R5: In sparse mode, a channel with `chan_en_i[c]` = 0 is never presented, even when its hit flag is set.
- R6: While `valid_o` is high, `sel_o` has exactly one bit set, at position `addr_o`; while `valid_o` is low, `sel_o` is all zeros.
- R7: `done_o` rises for one cycle in the clock after the last channel is presented, with `valid_o` low; `valid_o` and `done_o` are never high together.
- R8: A sparse readout with no eligible channel raises `done_o` in the cycle after the start and never raises `valid_o`.
- R9: During a readout, `start_i` is ignored, and changes to `hit_i`, `chan_en_i` and `all_mode_i` do not alter the sequence that was captured at start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hit_i | input | 32 | Per-channel hit flags |
| chan_en_i | input | 32 | Per-channel discriminator enable (0 = disabled) |
| all_mode_i | input | 1 | 1 = read all channels, 0 = read hit channels only |
| chip_sel_i | input | 1 | High when the external chip address matches the stored ID |
| start_i | input | 1 | Readout request |
| addr_o | output | 5 | Address of the presented channel |
| sel_o | output | 32 | One-hot channel select strobe |
| valid_o | output | 1 | A channel is being presented |
| done_o | output | 1 | Single-cycle end-of-readout flag |

## Verification
A corrupted pending-channel vector shows up at the ports within one clock. It appears as a channel out of ascending order, a repeated or missing address, or `done_o` arriving early or late against the count of eligible channels. A state register stuck busy shows up as a start that produces neither `valid_o` nor `done_o` in the next cycle. Any address and strobe that lose alignment break the rule that the set select bit sits at `addr_o`. This is visible in the very cycle it happens.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } seq_state_e;

endpackage

// File: rtl/hit_gate.sv
// Forms the per-channel eligibility vector used when a readout starts.
module hit_gate #(
    parameter int NUM_CH = 32
) (
    input  logic [NUM_CH-1:0] hit_i,
    input  logic [NUM_CH-1:0] en_i,
    input  logic              all_mode_i,
    output logic [NUM_CH-1:0] elig_o
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // A disabled discriminator never yields a hit; full mode takes every channel.
        assign elig_o[c] = all_mode_i | (hit_i[c] & en_i[c]);
    end

endmodule

// File: rtl/lowest_pick.sv
// Finds the lowest set bit of a vector as one-hot and as a binary index.
module lowest_pick #(
    parameter int NUM_CH = 32,
    parameter int ADDR_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] vec_i,
    output logic [NUM_CH-1:0] onehot_o,
    output logic [ADDR_W-1:0] idx_o,
    output logic              any_o
);

    assign onehot_o = vec_i & (~vec_i + NUM_CH'(1));
    assign any_o    = |vec_i;

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (onehot_o[i]) begin
                idx_o = idx_o | ADDR_W'(i);
            end
        end
    end

endmodule

// File: rtl/readout_sequencer.sv
module readout_sequencer
    import seq_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int ADDR_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hit_i,
    input  logic [NUM_CH-1:0] chan_en_i,
    input  logic              all_mode_i,
    input  logic              chip_sel_i,
    input  logic              start_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [NUM_CH-1:0] sel_o,
    output logic              valid_o,
    output logic              done_o
);

    typedef struct packed {
        seq_state_e        st;
        logic [NUM_CH-1:0] pend;
        logic [ADDR_W-1:0] addr;
        logic [NUM_CH-1:0] sel;
        logic              valid;
        logic              done;
        logic              all;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [NUM_CH-1:0] elig;
    logic [NUM_CH-1:0] src;
    logic [NUM_CH-1:0] pick_oh;
    logic [ADDR_W-1:0] pick_idx;
    logic              pick_any;
    logic              go;

    hit_gate #(.NUM_CH(NUM_CH)) i_gate (
        .hit_i      (hit_i),
        .en_i       (chan_en_i),
        .all_mode_i (all_mode_i),
        .elig_o     (elig)
    );

    assign go  = start_i & chip_sel_i;
    assign src = (r_q.st == ST_IDLE) ? elig : r_q.pend;

    lowest_pick #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_pick (
        .vec_i    (src),
        .onehot_o (pick_oh),
        .idx_o    (pick_idx),
        .any_o    (pick_any)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.done  = 1'b0;
        r_d.sel   = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (go) begin
                    r_d.all = all_mode_i;
                    if (pick_any) begin
                        r_d.valid = 1'b1;
                        r_d.sel   = pick_oh;
                        r_d.addr  = pick_idx;
                        r_d.pend  = src & ~pick_oh;
                        r_d.st    = ST_SCAN;
                    end else begin
                        r_d.done  = 1'b1;
                    end
                end
            end
            ST_SCAN: begin
                if (pick_any) begin
                    r_d.valid = 1'b1;
                    r_d.sel   = pick_oh;
                    r_d.addr  = pick_idx;
                    r_d.pend  = src & ~pick_oh;
                end else begin
                    r_d.done  = 1'b1;
                    r_d.st    = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, pend: '0, addr: '0, sel: '0,
                     valid: 1'b0, done: 1'b0, all: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign addr_o  = r_q.addr;
    assign sel_o   = r_q.sel;
    assign valid_o = r_q.valid;
    assign done_o  = r_q.done;

    // Strobe and address stay aligned (R6)
    p_sel_at_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (sel_o[addr_o] && $countones(sel_o) == 1));

    p_sel_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (sel_o == '0));

    // Sparse and full readouts both climb in address (R3)
    p_ascending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o)) |-> (addr_o > $past(addr_o)));

    // Full mode visits every address in turn (R4)
    p_all_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && r_q.all) |-> (addr_o == $past(addr_o) + 1'b1));

    // Done and valid are exclusive (R7)
    p_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && valid_o));

    // No qualified start in idle, no activity (R2)
    p_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !go) |=> (!valid_o && !done_o));

    // A qualified start with eligible channels presents one next cycle (R3)
    p_first_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && go && elig != '0) |=> valid_o);

    // Empty readout finishes at once (R8)
    p_empty_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && go && elig == '0) |=> (done_o && !valid_o));

endmodule

// File: tb/test_readout_sequencer.sv
module test_readout_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  hit = '0;
    logic [NCH-1:0]  en = '1;
    logic            all_mode = 1'b0;
    logic            chip_sel = 1'b0;
    logic            start = 1'b0;
    logic [4:0]      addr;
    logic [NCH-1:0]  sel;
    logic            valid;
    logic            done;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    readout_sequencer i_readout_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit),
        .chan_en_i  (en),
        .all_mode_i (all_mode),
        .chip_sel_i (chip_sel),
        .start_i    (start),
        .addr_o     (addr),
        .sel_o      (sel),
        .valid_o    (valid),
        .done_o     (done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
        end
    endtask

    // Drives one readout and checks the whole train against the captured request.
    task automatic run_readout(input logic [NCH-1:0] h, input logic [NCH-1:0] e,
                               input logic m, input bit perturb, input string req);
        int expq[NCH];
        int n = 0;
        for (int c = 0; c < NCH; c++) begin
            if (m || (h[c] && e[c])) begin
                expq[n] = c;
                n++;
            end
        end
        @(negedge clk);
        hit = h; en = e; all_mode = m; chip_sel = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc <= n + 1; cyc++) begin
            if (cyc < n) begin
                chk(valid && !done, req, {valid, done}, 2'b10);
                chk(addr == expq[cyc], req, addr, expq[cyc]);
                chk(sel == (NCH'(1) << expq[cyc]), req, sel, NCH'(1) << expq[cyc]);
            end else if (cyc == n) begin
                chk(done && !valid, {req, "/R7"}, {valid, done}, 2'b01);
            end else begin
                chk(!done && !valid && sel == '0, {req, "/R7"}, {valid, done}, 2'b00);
            end
            if (perturb && cyc == 0) begin
                start = 1'b1; hit = ~h; en = ~e; all_mode = ~m;
            end else if (perturb && cyc == 1) begin
                start = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(addr == 0 && sel == '0 && !valid && !done, "R1", {valid, done, sel}, 0);
    endtask

    task automatic t_no_chip_sel();
        @(negedge clk);
        hit = 32'hFFFF_FFFF; chip_sel = 1'b0; start = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!valid && !done && sel == '0, "R2", {valid, done}, 0);
        end
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_sparse();
        run_readout(32'h8000_0111, '1, 1'b0, 1'b0, "R3");
        run_readout(32'h0000_F00F, '1, 1'b0, 1'b0, "R3");
        run_readout(32'h8000_0000, '1, 1'b0, 1'b0, "R3");
    endtask

    task automatic t_full();
        run_readout(32'h0000_0004, 32'h0000_0000, 1'b1, 1'b0, "R4");
    endtask

    task automatic t_disabled();
        run_readout(32'hFFFF_00FF, 32'h0F0F_F0F5, 1'b0, 1'b0, "R5");
    endtask

    task automatic t_empty();
        run_readout(32'h0000_0000, '1, 1'b0, 1'b0, "R8");
        run_readout(32'hFFFF_FFFF, '0, 1'b0, 1'b0, "R8");
    endtask

    task automatic t_busy_ignore();
        run_readout(32'h0102_4810, '1, 1'b0, 1'b1, "R9");
        run_readout(32'h0000_0000, 32'h0000_0000, 1'b1, 1'b1, "R9");
    endtask

    task automatic t_alignment();
        run_readout(32'hAAAA_5555, '1, 1'b0, 1'b0, "R6");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_chip_sel();
        t_sparse();
        t_full();
        t_disabled();
        t_empty();
        t_busy_ignore();
        t_alignment();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule